// File: doc/BRIEF.md
# Calorimeter Jet Element Former

This block builds jet elements from pairs of calorimeter energy channels. Each jet element has one electromagnetic channel and one hadronic channel. Each channel arrives as a data word with a parity bit. The block registers every word on a common base-rate boundary, together with its mask bit, the shared threshold and the shared link-valid flag. It then checks parity and drops any channel that is bad, masked or arriving while the link is down. It adds the two surviving energies, forces sums below the low threshold to zero, and clips the result at the full-scale code.

The block runs from one clock at twice the base rate and counts the base periods itself. Each 10-bit jet element leaves as two 5-bit halves within one base period: low half first, high half second. A frame strobe marks the first half. The full-width energies and sticky per-channel parity-error flags are also brought out for later stages. One instance forms 12 jet elements from 24 channels. Several instances together cover the whole channel set.

Top module: `jet_elem_former`

## Requirements
- R1: While reset is held and directly after it, every full-width energy, every serial half and every error flag is zero, and the frame strobe is high.
- R2: Inputs presented during base period j are captured at the end of that period. The jet element energy (electromagnetic plus hadronic) appears on `je_et_o` for the whole of base period j+2 and stays constant within the period.
- R3: A sum of 1023 or more gives the code 1023 (all ten bits set). A sum of 1022 is passed unchanged.
- R4: A sum below `thr_i` gives zero. A sum equal to or above `thr_i` is kept. The comparison uses the unclipped sum, so threshold 1023 passes a sum of 1028 as 1023 and zeroes a sum of 1022.
- R5: Even parity is used: a channel is good when the XOR of its ten data bits and its parity bit is 0. A channel that fails the check contributes zero energy.
- R6: A parity failure seen while the link is valid sets that channel's error flag (`e_err_o`/`h_err_o` bit i for element i). The flag is set regardless of the mask and stays set until reset. It becomes visible in the same base period as the element's energy.
- R7: A set mask bit makes that channel contribute zero. The partner channel of the same element still contributes.
- R8: While `link_ok_i` is low, every jet element is zero and no error flag is set, whatever the parity.
- R9: While `frame_o` is high, `je_ser_o` carries bits 4:0 of each element. While it is low, it carries bits 9:5. Element i occupies bits 5i+4:5i.
- R10: After reset `frame_o` alternates every clock cycle, so each base period is two clocks long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| e_data_i | input | 120 | Electromagnetic energies, 10 bits per element |
| e_par_i | input | 12 | Electromagnetic parity bits |
| h_data_i | input | 120 | Hadronic energies, 10 bits per element |
| h_par_i | input | 12 | Hadronic parity bits |
| e_mask_i | input | 12 | Electromagnetic channel masks |
| h_mask_i | input | 12 | Hadronic channel masks |
| thr_i | input | 10 | Low noise threshold |
| link_ok_i | input | 1 | Input links valid |
| je_ser_o | output | 60 | Jet element halves, 5 bits per element |
| frame_o | output | 1 | High in the first half of a base period |
| je_et_o | output | 120 | Full-width jet element energies |
| e_err_o | output | 12 | Sticky electromagnetic parity-error flags |
| h_err_o | output | 12 | Sticky hadronic parity-error flags |

## Verification
The bench probes the clipping edge with sums of 1022, 1023 and 2046. A clip that is off by one shows up here as 1022 becoming 1023, or as a wrapped small value. It also probes the threshold edge with sums just below, equal to and above the threshold. It includes threshold 1023 with a sum above full scale, which catches both a strict comparison and a comparison made after clipping. Parity errors are injected on masked channels, on unmasked channels and while the link is down. This separates a flag that forgets its state, a flag gated by the mask, and a flag raised on a dead link. Every period is checked half by half, so swapped halves or output one period early or late fail at once.

// File: rtl/jef_pkg.sv
package jef_pkg;
   typedef enum logic {
      PH_LO = 1'b0,
      PH_HI = 1'b1
   } half_t;

   localparam int JEF_HALVES = 2;
endpackage

// File: rtl/jef_chan_check.sv
module jef_chan_check #(
   parameter int E_W     = 10,
   parameter bit PAR_ODD = 1'b0
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           adv_i,
   input  logic           link_i,
   input  logic [E_W-1:0] data_i,
   input  logic           par_i,
   input  logic           mask_i,
   output logic [E_W-1:0] en_o,
   output logic           err_o
);
   logic [E_W-1:0] word_q;
   logic           par_q;
   logic           mask_q;
   logic           par_bad;

   // capture on the base-period boundary
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         word_q <= '0;
         par_q  <= 1'b0;
         mask_q <= 1'b0;
      end else if (adv_i) begin
         word_q <= data_i;
         par_q  <= par_i;
         mask_q <= mask_i;
      end
   end

   generate
      if (PAR_ODD) begin : g_odd
         assign par_bad = ~(^{word_q, par_q});
      end else begin : g_even
         assign par_bad = ^{word_q, par_q};
      end
   endgenerate

   assign en_o = (link_i && !mask_q && !par_bad) ? word_q : '0;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         err_o <= 1'b0;
      end else if (adv_i && link_i && par_bad) begin
         err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/jef_elem_sum.sv
module jef_elem_sum #(
   parameter int E_W  = 10,
   parameter int JE_W = 10
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            adv_i,
   input  logic [E_W-1:0]  e_i,
   input  logic [E_W-1:0]  h_i,
   input  logic [JE_W-1:0] thr_i,
   output logic [JE_W-1:0] et_o
);
   localparam int SUM_W = E_W + 1;
   localparam int CMP_W = (SUM_W > JE_W) ? SUM_W : JE_W;
   localparam logic [CMP_W-1:0] FULL = CMP_W'({JE_W{1'b1}});

   logic [CMP_W-1:0] sum_x;
   logic [CMP_W-1:0] thr_x;
   logic [JE_W-1:0]  clipped;
   logic [JE_W-1:0]  et_d;

   assign sum_x = CMP_W'(e_i) + CMP_W'(h_i);
   assign thr_x = CMP_W'(thr_i);

   generate
      if (SUM_W > JE_W) begin : g_clip
         assign clipped = (sum_x >= FULL) ? FULL[JE_W-1:0] : sum_x[JE_W-1:0];
      end else begin : g_noclip
         assign clipped = sum_x[JE_W-1:0];
      end
   endgenerate

   // threshold is judged on the unclipped sum
   assign et_d = (sum_x >= thr_x) ? clipped : '0;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         et_o <= '0;
      end else if (adv_i) begin
         et_o <= et_d;
      end
   end
endmodule

// File: rtl/jef_serialiser.sv
module jef_serialiser
   import jef_pkg::*;
#(
   parameter int N_JE  = 12,
   parameter int JE_W  = 10,
   parameter int SER_W = JE_W / 2
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   input  logic [N_JE*JE_W-1:0]   et_i,
   output logic [N_JE*SER_W-1:0]  ser_o,
   output logic                   frame_o,
   output logic                   adv_o
);
   half_t half_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         half_q <= PH_LO;
      end else begin
         half_q <= (half_q == PH_LO) ? PH_HI : PH_LO;
      end
   end

   assign frame_o = (half_q == PH_LO);
   assign adv_o   = (half_q == PH_HI);

   generate
      for (genvar i = 0; i < N_JE; i++) begin : g_mux
         assign ser_o[i*SER_W +: SER_W] = (half_q == PH_LO)
                                        ? et_i[i*JE_W +: SER_W]
                                        : et_i[i*JE_W + SER_W +: SER_W];
      end
   endgenerate
endmodule

// File: rtl/jet_elem_former.sv
module jet_elem_former #(
   parameter int N_JE    = 12,
   parameter int E_W     = 10,
   parameter int JE_W    = 10,
   parameter bit PAR_ODD = 1'b0
) (
   input  logic                          clk_i,
   input  logic                          rst_i,
   input  logic [N_JE*E_W-1:0]           e_data_i,
   input  logic [N_JE-1:0]               e_par_i,
   input  logic [N_JE*E_W-1:0]           h_data_i,
   input  logic [N_JE-1:0]               h_par_i,
   input  logic [N_JE-1:0]               e_mask_i,
   input  logic [N_JE-1:0]               h_mask_i,
   input  logic [JE_W-1:0]               thr_i,
   input  logic                          link_ok_i,
   output logic [N_JE*(JE_W/2)-1:0]      je_ser_o,
   output logic                          frame_o,
   output logic [N_JE*JE_W-1:0]          je_et_o,
   output logic [N_JE-1:0]               e_err_o,
   output logic [N_JE-1:0]               h_err_o
);
   localparam int SER_W = JE_W / 2;

   generate
      if (JE_W != SER_W * jef_pkg::JEF_HALVES) begin : g_bad_split
         $error("jet element width must split into two equal halves");
      end
      if (N_JE < 1 || E_W < 1) begin : g_bad_size
         $error("element count and channel width must be positive");
      end
   endgenerate

   logic            adv;
   logic            link_q;
   logic [JE_W-1:0] thr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         link_q <= 1'b0;
         thr_q  <= '0;
      end else if (adv) begin
         link_q <= link_ok_i;
         thr_q  <= thr_i;
      end
   end

   generate
      for (genvar i = 0; i < N_JE; i++) begin : g_je
         logic [E_W-1:0] e_en;
         logic [E_W-1:0] h_en;

         jef_chan_check #(.E_W(E_W), .PAR_ODD(PAR_ODD)) u_e (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .adv_i  (adv),
            .link_i (link_q),
            .data_i (e_data_i[i*E_W +: E_W]),
            .par_i  (e_par_i[i]),
            .mask_i (e_mask_i[i]),
            .en_o   (e_en),
            .err_o  (e_err_o[i])
         );

         jef_chan_check #(.E_W(E_W), .PAR_ODD(PAR_ODD)) u_h (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .adv_i  (adv),
            .link_i (link_q),
            .data_i (h_data_i[i*E_W +: E_W]),
            .par_i  (h_par_i[i]),
            .mask_i (h_mask_i[i]),
            .en_o   (h_en),
            .err_o  (h_err_o[i])
         );

         jef_elem_sum #(.E_W(E_W), .JE_W(JE_W)) u_sum (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .adv_i (adv),
            .e_i   (e_en),
            .h_i   (h_en),
            .thr_i (thr_q),
            .et_o  (je_et_o[i*JE_W +: JE_W])
         );
      end
   endgenerate

   jef_serialiser #(.N_JE(N_JE), .JE_W(JE_W), .SER_W(SER_W)) u_ser (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .et_i    (je_et_o),
      .ser_o   (je_ser_o),
      .frame_o (frame_o),
      .adv_o   (adv)
   );
endmodule

// File: rtl/jef_checker.sv
module jef_checker #(
   parameter int N_JE = 12,
   parameter int JE_W = 10
) (
   input logic                     clk_i,
   input logic                     rst_i,
   input logic                     frame_o,
   input logic [N_JE*(JE_W/2)-1:0] je_ser_o,
   input logic [N_JE*JE_W-1:0]     je_et_o,
   input logic [N_JE-1:0]          e_err_o,
   input logic [N_JE-1:0]          h_err_o
);
   localparam int SER_W = JE_W / 2;

   p_frame_alt_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (frame_o != $past(frame_o)));

   p_et_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      !frame_o |-> $stable(je_et_o));

   p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      ((e_err_o & $past(e_err_o)) == $past(e_err_o)) &&
      ((h_err_o & $past(h_err_o)) == $past(h_err_o)));

   generate
      for (genvar i = 0; i < N_JE; i++) begin : g_half
         p_ser_lo_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            frame_o |-> (je_ser_o[i*SER_W +: SER_W] == je_et_o[i*JE_W +: SER_W]));
         p_ser_hi_r9: assert property (@(posedge clk_i) disable iff (rst_i)
            !frame_o |-> (je_ser_o[i*SER_W +: SER_W] == je_et_o[i*JE_W + SER_W +: SER_W]));
      end
   endgenerate
endmodule

bind jet_elem_former jef_checker #(.N_JE(N_JE), .JE_W(JE_W)) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .frame_o  (frame_o),
   .je_ser_o (je_ser_o),
   .je_et_o  (je_et_o),
   .e_err_o  (e_err_o),
   .h_err_o  (h_err_o)
);

// File: tb/jet_elem_former_tb_top.sv
`timescale 1ns/1ps
module jet_elem_former_tb_top;
   localparam int N  = 12;
   localparam int EW = 10;
   localparam int JW = 10;
   localparam int SW = JW / 2;

   typedef struct packed {
      logic [N*JW-1:0] et;
      logic [N-1:0]    ee;
      logic [N-1:0]    he;
      logic [7:0]      req;
      logic [31:0]     tag;
   } item_t;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [N*EW-1:0] e_data = '0, h_data = '0;
   logic [N-1:0]    e_par = '0, h_par = '0, e_mask = '0, h_mask = '0;
   logic [JW-1:0]   thr = '0;
   logic            link = 1'b0;
   logic [N*SW-1:0] ser;
   logic            frame;
   logic [N*JW-1:0] et;
   logic [N-1:0]    e_err, h_err;

   int total = 0;
   int bad   = 0;
   int per   = 0;
   logic prev_frame = 1'b1;
   int e_v[N];
   int h_v[N];
   logic [N-1:0] exp_ee = '0, exp_he = '0;
   item_t q[$];
   item_t cur;

   always #10 clk = ~clk;

   jet_elem_former dut_i (
      .clk_i(clk), .rst_i(rst),
      .e_data_i(e_data), .e_par_i(e_par), .h_data_i(h_data), .h_par_i(h_par),
      .e_mask_i(e_mask), .h_mask_i(h_mask), .thr_i(thr), .link_ok_i(link),
      .je_ser_o(ser), .frame_o(frame), .je_et_o(et),
      .e_err_o(e_err), .h_err_o(h_err)
   );

   task automatic check(input int req, input string what, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: compute expectation from the requirements and queue it
   task automatic send(input int req, input int th, input logic lk,
                       input logic [N-1:0] em, input logic [N-1:0] hm,
                       input logic [N-1:0] eb, input logic [N-1:0] hb);
      item_t it;
      @(negedge clk);
      while (frame !== 1'b0) @(negedge clk);
      thr  = th[JW-1:0];
      link = lk;
      e_mask = em;
      h_mask = hm;
      for (int i = 0; i < N; i++) begin
         int s, v;
         logic [EW-1:0] ed, hd;
         ed = e_v[i][EW-1:0];
         hd = h_v[i][EW-1:0];
         e_data[i*EW +: EW] = ed;
         h_data[i*EW +: EW] = hd;
         e_par[i] = (^ed) ^ eb[i];
         h_par[i] = (^hd) ^ hb[i];
         s = ((lk && !em[i] && !eb[i]) ? e_v[i] : 0) + ((lk && !hm[i] && !hb[i]) ? h_v[i] : 0);
         v = (s >= th) ? ((s > 1023) ? 1023 : s) : 0;
         it.et[i*JW +: JW] = v[JW-1:0];
      end
      if (lk) begin
         exp_ee = exp_ee | eb;
         exp_he = exp_he | hb;
      end
      it.ee  = exp_ee;
      it.he  = exp_he;
      it.req = req[7:0];
      it.tag = per + 2;
      q.push_back(it);
   endtask

   // monitor: pop and compare as the design produces each half
   initial begin
      forever begin
         @(negedge clk);
         if (!rst) begin
            check(10, "frame alternation", frame, !prev_frame); // R10
            prev_frame = frame;
            if (frame) begin
               per++;
               if (q.size() > 0 && q[0].tag == per) begin
                  cur = q[0];
                  for (int i = 0; i < N; i++) begin
                     check(cur.req, $sformatf("et[%0d]", i), et[i*JW +: JW], cur.et[i*JW +: JW]);
                     check(9, $sformatf("low half[%0d]", i), ser[i*SW +: SW], cur.et[i*JW +: SW]);
                  end
                  check(6, "e_err", e_err, cur.ee);
                  check(6, "h_err", h_err, cur.he);
               end
            end else if (q.size() > 0 && q[0].tag == per) begin
               cur = q.pop_front();
               for (int i = 0; i < N; i++) begin
                  check(9, $sformatf("high half[%0d]", i), ser[i*SW +: SW], cur.et[i*JW + SW +: SW]);
                  check(2, $sformatf("et held[%0d]", i), et[i*JW +: JW], cur.et[i*JW +: JW]);
               end
            end
         end
      end
   end

   initial begin
      #(20 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check(1, "et in reset", et, 0);
      check(1, "ser in reset", ser, 0);
      check(1, "e_err in reset", e_err, 0);
      check(1, "h_err in reset", h_err, 0);
      check(1, "frame in reset", frame, 1);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R2: plain sums, threshold zero
      for (int p = 0; p < 6; p++) begin
         for (int i = 0; i < N; i++) begin
            e_v[i] = $urandom_range(511);
            h_v[i] = $urandom_range(511);
         end
         send(2, 0, 1'b1, '0, '0, '0, '0);
      end

      // R3: clipping edge 1022 / 1023 / 2046
      for (int i = 0; i < N; i++) begin
         case (i % 3)
            0: begin e_v[i] = 1023; h_v[i] = 1023; end
            1: begin e_v[i] = 600;  h_v[i] = 423;  end
            default: begin e_v[i] = 600; h_v[i] = 422; end
         endcase
      end
      send(3, 0, 1'b1, '0, '0, '0, '0);
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < N; i++) begin
            e_v[i] = 400 + $urandom_range(623);
            h_v[i] = 400 + $urandom_range(623);
         end
         send(3, 0, 1'b1, '0, '0, '0, '0);
      end

      // R4: threshold edge, sums 45..56 against 50
      for (int i = 0; i < N; i++) begin
         e_v[i] = 25;
         h_v[i] = 20 + i;
      end
      send(4, 50, 1'b1, '0, '0, '0, '0);
      // R4: threshold at full scale vs unclipped sum
      for (int i = 0; i < N; i++) begin
         e_v[i] = (i % 2) ? 1000 : 1023;
         h_v[i] = (i % 2) ? 22 : 5;
      end
      send(4, 1023, 1'b1, '0, '0, '0, '0);

      // R5 and R6: parity failures then clean periods
      for (int i = 0; i < N; i++) begin
         e_v[i] = $urandom_range(700);
         h_v[i] = $urandom_range(700);
      end
      send(5, 0, 1'b1, '0, '0, 12'h005, 12'h820);
      for (int p = 0; p < 3; p++) begin
         for (int i = 0; i < N; i++) begin
            e_v[i] = $urandom_range(700);
            h_v[i] = $urandom_range(700);
         end
         send(6, 0, 1'b1, '0, '0, '0, '0);
      end

      // R7: masks, including a masked channel with bad parity
      for (int p = 0; p < 2; p++) begin
         for (int i = 0; i < N; i++) begin
            e_v[i] = $urandom_range(500);
            h_v[i] = $urandom_range(500);
         end
         send(7, 0, 1'b1, 12'h1F0, 12'h00F, (p == 0) ? 12'h100 : 12'h000, '0);
      end

      // R8: link down with every parity bad, then recovery
      for (int i = 0; i < N; i++) begin
         e_v[i] = 1 + $urandom_range(500);
         h_v[i] = 1 + $urandom_range(500);
      end
      send(8, 0, 1'b0, '0, '0, 12'hFFF, 12'hFFF);
      send(8, 0, 1'b1, '0, '0, '0, '0);

      repeat (12) @(negedge clk);
      check(2, "all queued results seen", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule